// File: doc/BRIEF.md
# Network Board Control and Parity Capture Registers

This block is the host-visible control and status register set of a network-interface board. A 16-bit host bus reaches three word registers. The first is a control/status word. Its writable bits drive the board reset, the exit from loopback, the network controller's attention line, two interrupt enables and the auxiliary memory bus enable. Its read-only bits show the controller's interrupt flag, the parity-error flag, the RAM size strap and four strapped RAM base address bits.

The memory path sends a one-cycle parity-error strobe together with the 20-bit failing address, the source of the error and the byte end of the word that failed. The first strobe that arrives while no error is pending is captured and raises the parity flag. The captured data then stays frozen until the host writes the acknowledge bit. The block combines the two interrupt sources, each gated by its own enable, into a single interrupt request.

Register select `host_sel`: 0 = control/status, 1 = parity control, 2 = failing address bits 15:0, 3 = unused.

Top module: `nic_board_regs`

## Requirements
- R1: Control/status bits 15 (board reset), 14 (on-air), 13 (attention), 12 (interrupt enable), 11 (parity interrupt enable) and 5 (auxiliary bus enable) are written from host_wdata when host_sel = 0 and read back at the same positions.
- R2: board_reset_o, on_air_o, attn_o and aux_bus_en_o each follow the level of their stored bit (15, 14, 13 and 5) from the clock edge that writes it.
- R3: While bit 15 is set, bits 14..11 read 0 and on_air_o and attn_o are low, whatever value the host writes to those bits.
- R4: Status bit 9 reads the parity flag, bit 8 reads the ctrl_irq_i level, bit 4 reads ram_256k_i and bits 3:0 read ram_base_i. Host writes do not change these bits. Bits 10, 7 and 6 read 0. Select 3 reads 0, and writes to it change nothing.
- R5: A perr_stb_i with no pending error captures the 20-bit address into select 2 (bits 15:0) and select 1 (bits 3:0). It also captures perr_src_i into select 1 bit 7 and perr_end_i into select 1 bit 6, and it sets the parity flag.
- R6: While the parity flag is set, further strobes leave the captured address, source and end unchanged.
- R7: A write to select 1 with bit 8 = 1 clears the parity flag. A write with bit 8 = 0 leaves it set. Select 1 bit 8 always reads 0.
- R8: A strobe in the same cycle as an acknowledge write captures the new error, and the flag stays set.
- R9: irq_o = (ctrl_irq_i AND bit 12) OR (parity flag AND bit 11).
- R10: After reset, every writable bit, the parity flag and all captured fields are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Register select |
| host_wr | input | 1 | Write strobe, one cycle per write |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data for host_sel |
| ctrl_irq_i | input | 1 | Interrupt level from network controller |
| ram_256k_i | input | 1 | RAM size strap |
| ram_base_i | input | 4 | RAM base address bits 20..17 strap |
| perr_stb_i | input | 1 | One-cycle parity error strobe |
| perr_addr_i | input | 20 | Failing address |
| perr_src_i | input | 1 | Error source |
| perr_end_i | input | 1 | Which byte end of the word failed |
| board_reset_o | output | 1 | Board reset |
| on_air_o | output | 1 | Leave loopback |
| attn_o | output | 1 | Controller attention |
| aux_bus_en_o | output | 1 | Auxiliary memory bus enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check four things on every cycle. Holding the board in reset keeps on-air and attention low. A pending parity error freezes the captured fields until acknowledged. A lone acknowledge clears the flag. An enabled pending source always raises the request. The bench's scenarios are needed for the rest. A sweep over all 64 writable-bit patterns covers the read-back layout and the reset masking. The bench also shows that read-only bits and select 3 ignore writes, that captured fields land at their bit positions over several addresses, and how a strobe colliding with an acknowledge resolves.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  localparam int unsigned WORD_W = 16;
  localparam logic [1:0] SEL_CTRL  = 2'd0;
  localparam logic [1:0] SEL_PCTL  = 2'd1;
  localparam logic [1:0] SEL_PADDR = 2'd2;

  localparam int unsigned B_RST   = 15;
  localparam int unsigned B_AIR   = 14;
  localparam int unsigned B_ATTN  = 13;
  localparam int unsigned B_IEN   = 12;
  localparam int unsigned B_PIEN  = 11;
  localparam int unsigned B_PFLAG = 9;
  localparam int unsigned B_IFLAG = 8;
  localparam int unsigned B_AUX   = 5;
  localparam int unsigned B_R256  = 4;

  localparam int unsigned B_ACK  = 8;
  localparam int unsigned B_PSRC = 7;
  localparam int unsigned B_PEND = 6;

  typedef struct packed {
    logic rst;
    logic air;
    logic attn;
    logic ien;
    logic pien;
    logic aux;
  } ctl_bits_t;
endpackage

// File: rtl/nic_rst_sync.sv
module nic_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/nic_ctl_word.sv
module nic_ctl_word
  import nic_regs_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  ctl_bits_t wr_bits,
  output ctl_bits_t bits_q
);
  ctl_bits_t bits_d;

  always_comb begin
    bits_d = bits_q;
    if (wr_en) begin
      bits_d     = wr_bits;
      bits_d.air  = wr_bits.air  & ~wr_bits.rst;
      bits_d.attn = wr_bits.attn & ~wr_bits.rst;
      bits_d.ien  = wr_bits.ien  & ~wr_bits.rst;
      bits_d.pien = wr_bits.pien & ~wr_bits.rst;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     bits_q <= '0;
    else if (wr_en) bits_q <= bits_d;
  end

  // R3: board reset held keeps the run controls low
  assert_reset_masks_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bits_q.rst |-> !(bits_q.air || bits_q.attn || bits_q.ien || bits_q.pien));
endmodule

// File: rtl/nic_perr_capture.sv
module nic_perr_capture #(
  parameter int unsigned ADDR_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              src_in,
  input  logic              end_in,
  input  logic              ack,
  output logic              flag_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic              src_q,
  output logic              end_q
);
  logic take;
  logic flag_d;
  logic flag_en;

  assign take    = stb & (~flag_q | ack);
  assign flag_d  = take | (flag_q & ~ack);
  assign flag_en = take | ack;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       flag_q <= 1'b0;
    else if (flag_en) flag_q <= flag_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      src_q  <= 1'b0;
      end_q  <= 1'b0;
    end else if (take) begin
      addr_q <= addr_in;
      src_q  <= src_in;
      end_q  <= end_in;
    end
  end

  // R6: pending error freezes the captured fields
  assert_capture_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && !ack) |=> ($stable(addr_q) && $stable(src_q) && $stable(end_q)));
  // R7: lone acknowledge clears the flag
  assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q && ack && !stb) |=> !flag_q);
  // R5: strobe with nothing pending raises the flag and stores the address
  assert_first_capture_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (stb && !flag_q) |=> (flag_q && addr_q == $past(addr_in)));
endmodule

// File: rtl/nic_board_regs.sv
module nic_board_regs
  import nic_regs_pkg::*;
#(
  parameter int unsigned PERR_ADDR_W = 20
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [1:0]             host_sel,
  input  logic                   host_wr,
  input  logic [WORD_W-1:0]      host_wdata,
  output logic [WORD_W-1:0]      host_rdata,
  input  logic                   ctrl_irq_i,
  input  logic                   ram_256k_i,
  input  logic [3:0]             ram_base_i,
  input  logic                   perr_stb_i,
  input  logic [PERR_ADDR_W-1:0] perr_addr_i,
  input  logic                   perr_src_i,
  input  logic                   perr_end_i,
  output logic                   board_reset_o,
  output logic                   on_air_o,
  output logic                   attn_o,
  output logic                   aux_bus_en_o,
  output logic                   irq_o
);
  localparam int unsigned HI_W = PERR_ADDR_W - WORD_W;

  logic      srst_n;
  logic      wr_ctrl;
  logic      ack;
  ctl_bits_t wr_bits;
  ctl_bits_t bits;
  logic      pflag;
  logic [PERR_ADDR_W-1:0] paddr;
  logic      psrc;
  logic      pend;

  nic_rst_sync #(.STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(srst_n)
  );

  assign wr_ctrl = host_wr && (host_sel == SEL_CTRL);
  assign ack     = host_wr && (host_sel == SEL_PCTL) && host_wdata[B_ACK];

  assign wr_bits = '{rst: host_wdata[B_RST], air: host_wdata[B_AIR],
                     attn: host_wdata[B_ATTN], ien: host_wdata[B_IEN],
                     pien: host_wdata[B_PIEN], aux: host_wdata[B_AUX]};

  nic_ctl_word u_ctl (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_ctrl), .wr_bits(wr_bits), .bits_q(bits)
  );

  nic_perr_capture #(.ADDR_W(PERR_ADDR_W)) u_perr (
    .clk(clk), .rst_n(srst_n), .stb(perr_stb_i), .addr_in(perr_addr_i),
    .src_in(perr_src_i), .end_in(perr_end_i), .ack(ack),
    .flag_q(pflag), .addr_q(paddr), .src_q(psrc), .end_q(pend)
  );

  always_comb begin
    host_rdata = '0;
    case (host_sel)
      SEL_CTRL: begin
        host_rdata[B_RST]   = bits.rst;
        host_rdata[B_AIR]   = bits.air;
        host_rdata[B_ATTN]  = bits.attn;
        host_rdata[B_IEN]   = bits.ien;
        host_rdata[B_PIEN]  = bits.pien;
        host_rdata[B_PFLAG] = pflag;
        host_rdata[B_IFLAG] = ctrl_irq_i;
        host_rdata[B_AUX]   = bits.aux;
        host_rdata[B_R256]  = ram_256k_i;
        host_rdata[3:0]     = ram_base_i;
      end
      SEL_PCTL: begin
        host_rdata[B_PSRC]   = psrc;
        host_rdata[B_PEND]   = pend;
        host_rdata[HI_W-1:0] = paddr[PERR_ADDR_W-1:WORD_W];
      end
      SEL_PADDR: host_rdata = paddr[WORD_W-1:0];
      default:   host_rdata = '0;
    endcase
  end

  assign board_reset_o = bits.rst;
  assign on_air_o      = bits.air;
  assign attn_o        = bits.attn;
  assign aux_bus_en_o  = bits.aux;
  assign irq_o         = (ctrl_irq_i & bits.ien) | (pflag & bits.pien);

  // R9: enabled pending parity error always raises the request
  assert_parity_irq_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (pflag && bits.pien) |-> irq_o);
  // R9: no source, no request
  assert_quiet_irq_R9: assert property (@(posedge clk) disable iff (!srst_n)
    (!ctrl_irq_i && !pflag) |-> !irq_o);
  // R3: reset output excludes on-air and attention
  assert_reset_outputs_R3: assert property (@(posedge clk) disable iff (!srst_n)
    board_reset_o |-> (!on_air_o && !attn_o));
endmodule

// File: tb/nic_board_regs_bench.sv
module nic_board_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  host_sel = '0;
  logic        host_wr = 1'b0;
  logic [15:0] host_wdata = '0;
  logic [15:0] host_rdata;
  logic        ctrl_irq_i = 1'b0;
  logic        ram_256k_i = 1'b0;
  logic [3:0]  ram_base_i = '0;
  logic        perr_stb_i = 1'b0;
  logic [19:0] perr_addr_i = '0;
  logic        perr_src_i = 1'b0;
  logic        perr_end_i = 1'b0;
  logic        board_reset_o, on_air_o, attn_o, aux_bus_en_o, irq_o;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  nic_board_regs u_nic_board_regs (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .ctrl_irq_i(ctrl_irq_i),
    .ram_256k_i(ram_256k_i), .ram_base_i(ram_base_i), .perr_stb_i(perr_stb_i),
    .perr_addr_i(perr_addr_i), .perr_src_i(perr_src_i), .perr_end_i(perr_end_i),
    .board_reset_o(board_reset_o), .on_air_o(on_air_o), .attn_o(attn_o),
    .aux_bus_en_o(aux_bus_en_o), .irq_o(irq_o)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h expected=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] sel, output logic [15:0] d);
    @(negedge clk);
    host_sel = sel;
    #1 d = host_rdata;
  endtask

  task automatic strobe(input logic [19:0] a, input logic s, input logic e);
    @(negedge clk);
    perr_addr_i = a; perr_src_i = s; perr_end_i = e; perr_stb_i = 1'b1;
    @(negedge clk);
    perr_stb_i = 1'b0;
  endtask

  function automatic logic [15:0] ctl_word(input logic [5:0] b, input logic pf,
                                           input logic ir, input logic r2, input logic [3:0] rb);
    logic [15:0] w;
    logic [3:0] run;
    run = b[4:1] & {4{~b[5]}};
    w = '0;
    w[15] = b[5]; w[14:11] = run; w[9] = pf; w[8] = ir; w[5] = b[0];
    w[4] = r2; w[3:0] = rb;
    return w;
  endfunction

  initial begin
    logic [15:0] d;
    logic [15:0] exp;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R10 reset state
    rd(2'd0, d); chk("R10 ctrl", d, 16'h0000);
    rd(2'd1, d); chk("R10 pctl", d, 16'h0000);
    rd(2'd2, d); chk("R10 paddr", d, 16'h0000);
    chk("R10 outputs", {board_reset_o, on_air_o, attn_o, aux_bus_en_o, irq_o}, 0);

    // R1 R2 R3 R4: sweep all writable patterns, all other bits set in write
    for (int p = 0; p < 64; p++) begin
      logic [5:0] b;
      b = p[5:0];
      ram_base_i = p[3:0] ^ 4'h5; ram_256k_i = p[0];
      wr(2'd0, {b[5], b[4:1], 5'b11111, b[0], 5'b11111});
      rd(2'd0, d);
      exp = ctl_word(b, 1'b0, 1'b0, p[0], p[3:0] ^ 4'h5);
      chk("R1 R3 R4 readback", d, exp);
      chk("R2 R3 outputs", {board_reset_o, on_air_o, attn_o, aux_bus_en_o},
          {b[5], b[4] & ~b[5], b[3] & ~b[5], b[0]});
    end

    // R4 select 3 ignored and reads 0
    wr(2'd0, 16'h0000);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, d); chk("R4 sel3", d, 0);
    rd(2'd0, d); chk("R4 sel3 no effect", d, ctl_word(6'd0, 0, 0, ram_256k_i, ram_base_i));
    ctrl_irq_i = 1'b1;
    rd(2'd0, d); chk("R4 int flag bit8", d[8], 1);
    ctrl_irq_i = 1'b0;

    // R5 R6 R7: several addresses
    for (int k = 0; k < 6; k++) begin
      logic [19:0] a;
      a = 20'h12345 * (k + 1) ^ 20'hA5A5A;
      strobe(a, k[0], k[1]);
      rd(2'd2, d); chk("R5 addr low", d, a[15:0]);
      rd(2'd1, d); chk("R5 pctl", d, {8'h00, k[0], k[1], 2'b00, a[19:16]});
      rd(2'd0, d); chk("R5 flag", d[9], 1);
      strobe(~a, ~k[0], ~k[1]);
      rd(2'd2, d); chk("R6 addr held", d, a[15:0]);
      rd(2'd1, d); chk("R6 pctl held", d, {8'h00, k[0], k[1], 2'b00, a[19:16]});
      wr(2'd1, 16'hFEFF);
      rd(2'd0, d); chk("R7 no-ack keeps flag", d[9], 1);
      rd(2'd1, d); chk("R7 bit8 reads 0", d[8], 0);
      wr(2'd1, 16'h0100);
      rd(2'd0, d); chk("R7 ack clears", d[9], 0);
    end

    // R8 strobe collides with ack
    strobe(20'h0000F, 1'b0, 1'b0);
    @(negedge clk);
    host_sel = 2'd1; host_wdata = 16'h0100; host_wr = 1'b1;
    perr_addr_i = 20'hBEEF1; perr_src_i = 1'b1; perr_end_i = 1'b0; perr_stb_i = 1'b1;
    @(negedge clk);
    host_wr = 1'b0; perr_stb_i = 1'b0;
    rd(2'd0, d); chk("R8 flag stays", d[9], 1);
    rd(2'd2, d); chk("R8 new addr", d, 16'hEEF1);
    rd(2'd1, d); chk("R8 new pctl", d, 16'h008B);
    wr(2'd1, 16'h0100);

    // R9 exhaustive over the four terms
    for (int m = 0; m < 16; m++) begin
      wr(2'd1, 16'h0100);
      if (m[3]) strobe(20'h1, 1'b0, 1'b0);
      wr(2'd0, {3'b000, m[1], m[0], 11'h0});
      ctrl_irq_i = m[2];
      #1 chk("R9 irq", irq_o, (m[2] & m[1]) | (m[3] & m[0]));
      ctrl_irq_i = 1'b0;
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired got=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule